// File: doc/BRIEF.md
# DSP Half-Word Multiply Accumulator

This block holds the 64-bit accumulator of a 32-bit processor's DSP extension. Each command takes two 32-bit register operands. A multiply command picks either the upper or the lower 16-bit half of both operands and forms their signed product. It then shifts that product up by 16 bits and either loads it into the accumulator or adds it to the accumulator.

Software can read three 32-bit windows of the accumulator: the top word, the bottom word and a middle slice. It can overwrite the top word or the bottom word. A round command shifts the accumulator left by one or two places, adds a half-unit bias at bit 31 and clamps the result to a fixed signed range. It returns the value with its bottom word cleared.

A command is a 4-bit operation code, two operands and a valid strobe. Every command takes effect at the clock edge where the strobe is sampled high. The reset input clears the accumulator at once and is released in step with the clock.

Top module: `dsp_acc_top`

## Requirements
- R1: Two cycles after `rst_n` is released, the accumulator reads back as zero and `rdata_o` is zero.
- R2: Operation code 1 (multiply upper) loads the accumulator with the signed product of `opa_i[31:16]` and `opb_i[31:16]`, sign-extended to 64 bits and shifted left by 16.
- R3: Operation code 2 (multiply lower) does the same with `opa_i[15:0]` and `opb_i[15:0]`.
- R4: Operation codes 3 (accumulate upper) and 4 (accumulate lower) add that same aligned product to the accumulator, modulo 2^64.
- R5: Operation codes 5, 6 and 7 place accumulator bits 63:32, 47:16 and 31:0 on `rdata_o` at the command's clock edge. They leave the accumulator unchanged.
- R6: Operation code 8 writes `opa_i` into accumulator bits 63:32 and keeps bits 31:0. Operation code 9 writes `opa_i` into bits 31:0 and keeps bits 63:32.
- R7: Operation code 10 (round) shifts the accumulator left by 2 when `opa_i` equals 2, and by 1 for any other value. It then adds 0x0000_0000_8000_0000 and stores the sum with bits 31:0 cleared.
- R8: If the rounded sum, read as signed, exceeds 0x00007FFF_00000000, the accumulator becomes 0x00007FFF_00000000.
- R9: If the rounded sum, read as signed, is below 0xFFFF8000_00000000, the accumulator becomes 0xFFFF8000_00000000.
- R10: A clock edge with `valid_i` low, or with an operation code of 0 or of 11 to 15, changes neither the accumulator nor `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts at once, releases in step with the clock |
| valid_i | input | 1 | Command strobe |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand (also the write data, and the round shift selector) |
| opb_i | input | 32 | Second operand |
| rdata_o | output | 32 | Registered accumulator read window |

## Verification
The saturation paths of the round command are the hardest cases to reach. Reaching them through multiply-accumulate alone would take long command chains. Instead, the stimulus uses the word writes to place values just beyond each bound. It then rounds with both shift amounts and checks the clamped result. It also places values whose bias addition carries into the top word without clamping. Both rounding directions of the bias are checked through the read windows.

// File: rtl/dsp_acc_pkg.sv
package dsp_acc_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE   = 4'd0,
    OP_MUL_UP = 4'd1,
    OP_MUL_DN = 4'd2,
    OP_MAC_UP = 4'd3,
    OP_MAC_DN = 4'd4,
    OP_GET_TP = 4'd5,
    OP_GET_MD = 4'd6,
    OP_GET_BT = 4'd7,
    OP_SET_TP = 4'd8,
    OP_SET_BT = 4'd9,
    OP_RNDSAT = 4'd10
  } acc_op_e;

  typedef struct packed {
    logic acc_en;
    logic rd_en;
    logic use_round;
    logic use_prod;
    logic add_prod;
    logic hi_half;
  } acc_ctl_t;

endpackage

// File: rtl/dsp_acc_rst_sync.sv
module dsp_acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dsp_acc_mul.sv
module dsp_acc_mul #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              hi_half,
  output logic [ACC_W-1:0]  prod_aligned
);

  localparam int HALF_W = DATA_W / 2;
  localparam int EXT_W  = ACC_W - DATA_W;

  logic signed [HALF_W-1:0] half_a;
  logic signed [HALF_W-1:0] half_b;
  logic signed [DATA_W-1:0] prod;
  logic        [ACC_W-1:0]  prod_ext;

  always_comb begin
    if (hi_half) begin
      half_a = opa[DATA_W-1:HALF_W];
      half_b = opb[DATA_W-1:HALF_W];
    end else begin
      half_a = opa[HALF_W-1:0];
      half_b = opb[HALF_W-1:0];
    end
    prod         = half_a * half_b;
    prod_ext     = {{EXT_W{prod[DATA_W-1]}}, prod};
    prod_aligned = prod_ext << HALF_W;
  end

endmodule

// File: rtl/dsp_acc_round.sv
module dsp_acc_round #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 2 * DATA_W
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic [DATA_W-1:0] amount,
  output logic [ACC_W-1:0]  result
);

  localparam int HALF_W = DATA_W / 2;
  localparam logic [ACC_W-1:0] BIAS =
    {{DATA_W{1'b0}}, 1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] CLAMP_HI =
    {{HALF_W{1'b0}}, 1'b0, {(HALF_W-1){1'b1}}, {DATA_W{1'b0}}};
  localparam logic [ACC_W-1:0] CLAMP_LO =
    {{HALF_W{1'b1}}, 1'b1, {(HALF_W-1){1'b0}}, {DATA_W{1'b0}}};

  logic             by_two;
  logic [ACC_W-1:0] shifted;
  logic [ACC_W-1:0] biased;
  logic             over_hi;
  logic             under_lo;

  always_comb begin
    by_two   = (amount == DATA_W'(2));
    shifted  = by_two ? (acc << 2) : (acc << 1);
    biased   = shifted + BIAS;
    over_hi  = $signed(biased) > $signed(CLAMP_HI);
    under_lo = $signed(biased) < $signed(CLAMP_LO);
    if (over_hi) begin
      result = CLAMP_HI;
    end else if (under_lo) begin
      result = CLAMP_LO;
    end else begin
      result = {biased[ACC_W-1:DATA_W], {DATA_W{1'b0}}};
    end
  end

endmodule

// File: rtl/dsp_acc_top.sv
module dsp_acc_top
  import dsp_acc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int ACC_W  = 2 * DATA_W;
  localparam int HALF_W = DATA_W / 2;

  logic             rst_sync_n;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [DATA_W-1:0] rd_d;
  logic [ACC_W-1:0] prod_aligned;
  logic [ACC_W-1:0] round_res;
  acc_ctl_t         ctl;
  acc_op_e          op;

  dsp_acc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dsp_acc_mul #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mul (
    .opa          (opa_i),
    .opb          (opb_i),
    .hi_half      (ctl.hi_half),
    .prod_aligned (prod_aligned)
  );

  dsp_acc_round #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_rnd (
    .acc    (acc_q),
    .amount (opa_i),
    .result (round_res)
  );

  // Command decode
  always_comb begin
    op  = acc_op_e'(op_i);
    ctl = '0;
    if (valid_i) begin
      case (op)
        OP_MUL_UP: begin ctl.acc_en = 1'b1; ctl.use_prod = 1'b1; ctl.hi_half = 1'b1; end
        OP_MUL_DN: begin ctl.acc_en = 1'b1; ctl.use_prod = 1'b1; end
        OP_MAC_UP: begin ctl.acc_en = 1'b1; ctl.use_prod = 1'b1; ctl.add_prod = 1'b1; ctl.hi_half = 1'b1; end
        OP_MAC_DN: begin ctl.acc_en = 1'b1; ctl.use_prod = 1'b1; ctl.add_prod = 1'b1; end
        OP_GET_TP, OP_GET_MD, OP_GET_BT: ctl.rd_en = 1'b1;
        OP_SET_TP, OP_SET_BT: ctl.acc_en = 1'b1;
        OP_RNDSAT: begin ctl.acc_en = 1'b1; ctl.use_round = 1'b1; end
        default: ctl = '0;
      endcase
    end
  end

  // Next-state for accumulator and read window
  always_comb begin
    acc_d = acc_q;
    if (ctl.use_round) begin
      acc_d = round_res;
    end else if (ctl.use_prod) begin
      acc_d = ctl.add_prod ? (acc_q + prod_aligned) : prod_aligned;
    end else if (op == OP_SET_TP) begin
      acc_d = {opa_i, acc_q[DATA_W-1:0]};
    end else if (op == OP_SET_BT) begin
      acc_d = {acc_q[ACC_W-1:DATA_W], opa_i};
    end

    case (op)
      OP_GET_TP: rd_d = acc_q[ACC_W-1:DATA_W];
      OP_GET_MD: rd_d = acc_q[ACC_W-HALF_W-1:HALF_W];
      default:   rd_d = acc_q[DATA_W-1:0];
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q   <= '0;
      rdata_o <= '0;
    end else begin
      if (ctl.acc_en) begin
        acc_q <= acc_d;
      end
      if (ctl.rd_en) begin
        rdata_o <= rd_d;
      end
    end
  end

endmodule

// File: rtl/dsp_acc_chk.sv
module dsp_acc_chk
  import dsp_acc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                valid_i,
  input logic [OP_W-1:0]     op_i,
  input logic [DATA_W-1:0]   opa_i,
  input logic [DATA_W-1:0]   opb_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [2*DATA_W-1:0] acc_q
);

  localparam int ACC_W  = 2 * DATA_W;
  localparam int HALF_W = DATA_W / 2;
  localparam logic [ACC_W-1:0] CLAMP_HI =
    {{HALF_W{1'b0}}, 1'b0, {(HALF_W-1){1'b1}}, {DATA_W{1'b0}}};
  localparam logic [ACC_W-1:0] CLAMP_LO =
    {{HALF_W{1'b1}}, 1'b1, {(HALF_W-1){1'b0}}, {DATA_W{1'b0}}};

  logic is_rd, is_round, is_nop;
  assign is_rd    = valid_i && (op_i == OP_GET_TP || op_i == OP_GET_MD || op_i == OP_GET_BT);
  assign is_round = valid_i && (op_i == OP_RNDSAT);
  assign is_nop   = !valid_i || op_i == OP_IDLE || op_i > OP_RNDSAT;

  AST_MUL_UP_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && op_i == OP_MUL_UP) |=> $signed(acc_q) ==
      ($signed(ACC_W'($signed($past(opa_i[DATA_W-1:HALF_W])) * $signed($past(opb_i[DATA_W-1:HALF_W])))) <<< HALF_W)); // R2
  AST_READ_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_rd |=> $stable(acc_q)); // R5
  AST_READ_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && op_i == OP_GET_TP) |=> rdata_o == $past(acc_q[ACC_W-1:DATA_W])); // R5
  AST_SET_TOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && op_i == OP_SET_TP) |=> acc_q[ACC_W-1:DATA_W] == $past(opa_i) && acc_q[DATA_W-1:0] == $past(acc_q[DATA_W-1:0])); // R6
  AST_SET_BOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && op_i == OP_SET_BT) |=> acc_q[DATA_W-1:0] == $past(opa_i) && acc_q[ACC_W-1:DATA_W] == $past(acc_q[ACC_W-1:DATA_W])); // R6
  AST_ROUND_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_round |=> acc_q[DATA_W-1:0] == '0); // R7
  AST_ROUND_UPPER_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_round |=> $signed(acc_q) <= $signed(CLAMP_HI)); // R8
  AST_ROUND_LOWER_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_round |=> $signed(acc_q) >= $signed(CLAMP_LO)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_nop |=> $stable(acc_q) && $stable(rdata_o)); // R10

endmodule

bind dsp_acc_top dsp_acc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .opa_i      (opa_i),
  .opb_i      (opb_i),
  .rdata_o    (rdata_o),
  .acc_q      (acc_q)
);

// File: tb/dsp_acc_top_test.sv
module dsp_acc_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [3:0]  op_i;
  logic [31:0] opa_i;
  logic [31:0] opb_i;
  logic [31:0] rdata_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] model;

  always #2 clk = ~clk;

  dsp_acc_top uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .op_i    (op_i),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .rdata_o (rdata_o)
  );

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b, input logic v = 1'b1);
    @(negedge clk);
    valid_i = v; op_i = op; opa_i = a; opb_i = b;
    @(negedge clk);
    valid_i = 1'b0; op_i = 4'd0; opa_i = '0; opb_i = '0;
  endtask

  task automatic read_acc(output logic [63:0] v);
    issue(4'd5, '0, '0); v[63:32] = rdata_o;
    issue(4'd7, '0, '0); v[31:0]  = rdata_o;
  endtask

  function automatic logic [63:0] aligned(input logic [15:0] x, input logic [15:0] y);
    longint p;
    p = longint'($signed(x)) * longint'($signed(y));
    return 64'(p) << 16;
  endfunction

  function automatic logic [63:0] rnd_model(input logic [63:0] acc, input logic [31:0] amt);
    longint s;
    s = longint'(acc << ((amt == 32'd2) ? 2 : 1)) + 64'h8000_0000;
    if (s > 64'sh00007FFF_00000000) return 64'h00007FFF_00000000;
    if (s < 64'shFFFF8000_00000000) return 64'hFFFF8000_00000000;
    return {s[63:32], 32'h0};
  endfunction

  task automatic load(input logic [63:0] v);
    issue(4'd8, v[63:32], '0);
    issue(4'd9, v[31:0], '0);
  endtask

  task automatic t_reset;
    logic [63:0] v;
    checks++;
    if (rdata_o !== 32'h0) begin
      errors++; $display("FAIL R1: rdata %h expected 0", rdata_o);
    end
    read_acc(v);
    check64("R1 acc after reset", v, 64'h0);
  endtask

  task automatic t_mul;
    logic [63:0] v;
    issue(4'd1, 32'hFFFF_1234, 32'h0003_8000);
    read_acc(v); check64("R2 mul upper", v, aligned(16'hFFFF, 16'h0003));
    issue(4'd1, 32'h8000_0000, 32'h8000_0000);
    read_acc(v); check64("R2 mul upper min*min", v, aligned(16'h8000, 16'h8000));
    issue(4'd2, 32'h7FFF_8000, 32'h1111_8000);
    read_acc(v); check64("R3 mul lower", v, aligned(16'h8000, 16'h8000));
    issue(4'd2, 32'h0000_FFFE, 32'h0000_0005);
    read_acc(v); check64("R3 mul lower neg", v, aligned(16'hFFFE, 16'h0005));
  endtask

  task automatic t_mac;
    logic [63:0] v;
    model = 64'h0000_0001_0000_0000;
    load(model);
    issue(4'd3, 32'h0100_0000, 32'h0200_0000);
    model += aligned(16'h0100, 16'h0200);
    issue(4'd4, 32'h0000_FFFF, 32'h0000_7FFF);
    model += aligned(16'hFFFF, 16'h7FFF);
    read_acc(v); check64("R4 mac mix", v, model);
    load(64'hFFFF_FFFF_FFFF_0000);
    issue(4'd4, 32'h0000_0001, 32'h0000_0001);
    read_acc(v); check64("R4 mac wrap", v, 64'h0);
  endtask

  task automatic t_reads;
    load(64'h0123_4567_89AB_CDEF);
    issue(4'd6, '0, '0);
    check64("R5 middle slice", {32'h0, rdata_o}, {32'h0, 32'h4567_89AB});
    issue(4'd5, '0, '0);
    check64("R5 top slice", {32'h0, rdata_o}, {32'h0, 32'h0123_4567});
    issue(4'd7, '0, '0);
    check64("R5 bottom slice", {32'h0, rdata_o}, {32'h0, 32'h89AB_CDEF});
  endtask

  task automatic t_writes;
    logic [63:0] v;
    load(64'hAAAA_BBBB_CCCC_DDDD);
    issue(4'd8, 32'h1357_9BDF, '0);
    read_acc(v); check64("R6 top write keeps bottom", v, 64'h1357_9BDF_CCCC_DDDD);
    issue(4'd9, 32'h2468_ACE0, '0);
    read_acc(v); check64("R6 bottom write keeps top", v, 64'h1357_9BDF_2468_ACE0);
  endtask

  task automatic t_round(input string req, input logic [63:0] start, input logic [31:0] amt);
    logic [63:0] v;
    load(start);
    issue(4'd10, amt, '0);
    read_acc(v); check64(req, v, rnd_model(start, amt));
  endtask

  task automatic t_ignore;
    logic [63:0] v;
    load(64'h0000_1111_2222_3333);
    issue(4'd7, '0, '0);
    issue(4'd8, 32'hDEAD_BEEF, '0, 1'b0);
    check64("R10 rdata held (valid low)", {32'h0, rdata_o}, {32'h0, 32'h2222_3333});
    issue(4'd15, 32'hDEAD_BEEF, 32'h1, 1'b1);
    issue(4'd0, 32'hDEAD_BEEF, 32'h1, 1'b1);
    check64("R10 rdata held (unused code)", {32'h0, rdata_o}, {32'h0, 32'h2222_3333});
    read_acc(v); check64("R10 acc untouched", v, 64'h0000_1111_2222_3333);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; op_i = '0; opa_i = '0; opb_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_mul();
    t_mac();
    t_reads();
    t_writes();
    t_round("R7 round by 1", 64'h0000_0001_4000_0000, 32'd1);
    t_round("R7 round by 2", 64'h0000_0001_4000_0000, 32'd2);
    t_round("R7 odd amount acts as 1", 64'h0000_0001_4000_0000, 32'd7);
    t_round("R7 bias carry into top word", 64'h0000_0001_C000_0000, 32'd1);
    t_round("R7 negative no clamp", 64'hFFFF_FFF0_0000_0000, 32'd2);
    t_round("R8 clamp high", 64'h0000_4000_0000_0000, 32'd1);
    t_round("R8 clamp high by 2", 64'h0000_2000_0000_0000, 32'd2);
    t_round("R8 exact upper bound kept", 64'h0000_3FFF_8000_0000, 32'd1);
    t_round("R9 clamp low", 64'hFFFF_C000_0000_0000, 32'd2);
    t_round("R9 clamp low by 1", 64'hFFFF_7000_0000_0000, 32'd1);
    t_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule